// File: doc/BRIEF.md
# Singlet-Aware Spill Replacement Controller

This block chooses the victim way for one set of a private second-level cache whose owner cooperates with the private caches of the other cores. For every way it keeps an exact recency rank, a flag that marks the block as the only copy held anywhere on the chip, and a flag that marks a block that reached this cache by being pushed out of a peer. On a fill it names the way that receives the new block and decides whether the block leaving that way is simply dropped or is sent on to a peer cache, and to which core.

Two 8-bit thresholds throttle the cooperative behaviour. The cooperation threshold decides, for each replacement, whether replicated blocks are preferred as victims and whether spilling is allowed at all. The spill threshold decides whether an eligible sole copy is really sent away. Both are compared against a free-running pseudo-random sequence, and the same sequence supplies the index of the receiving core. A block that was pushed in by a peer and is not used again before it falls out of the set leaves the chip, so no block travels between peers more than once without reuse.

Top module: `spill_repl_ctrl`

## Requirements
- R1: After reset all ways are empty and `victim_valid` and `spill_req` are 0; while any way is empty a fill takes the lowest-numbered empty way and never requests a spill.
- R2: Each fill produces exactly one cycle of `victim_valid` on the clock edge after the fill is presented, with `victim_way` and the spill fields valid in that cycle; without a fill `victim_valid` stays 0.
- R3: With the cooperation threshold 0 and the set full, the victim is the least recently used way and `spill_req` is 0. A hit or a fill makes its way the most recently used.
- R4: With the cooperation threshold 255 and the set full, if any way holds a replicated block (singlet flag 0) the victim is the least recently used of those ways, even when a singlet is older.
- R5: With the cooperation threshold 255 and every way holding a singlet, the victim is the least recently used way.
- R6: With the cooperation threshold 255, `spill_req` is 1 exactly when the victim holds a singlet that did not arrive by spill (or was reused since), and the spill threshold admits it; spill threshold 255 always admits and 0 never does.
- R7: A fill with `fill_from_peer` 1 places the block at the most recently used position with its spilled flag set; if that block later becomes the victim without a hit in between, `spill_req` is 0.
- R8: A hit clears the spilled flag of its way, so that the block may be spilled again when it is next evicted as a singlet.
- R9: Whenever `spill_req` is 1, `spill_target` is below NCORES and differs from CORE_ID.
- R10: A directory update (`dir_valid`) sets the singlet flag of `dir_way` to `dir_singlet` without changing recency; a fill sets the flag of its way from `fill_singlet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Local hit in this set |
| hit_way | input | $clog2(WAYS) | Way that hit |
| fill_valid | input | 1 | A block is to be allocated in this set |
| fill_singlet | input | 1 | The incoming block is the only on-chip copy |
| fill_from_peer | input | 1 | The incoming block was spilled here by a peer |
| dir_valid | input | 1 | Directory singlet-status update |
| dir_way | input | $clog2(WAYS) | Way the update refers to |
| dir_singlet | input | 1 | New singlet flag value |
| coop_thresh | input | 8 | Cooperation threshold, 0 = never, 255 = always |
| spill_thresh | input | 8 | Spill threshold, 0 = never, 255 = always |
| victim_valid | output | 1 | Replacement decision valid |
| victim_way | output | $clog2(WAYS) | Way that receives the new block |
| spill_req | output | 1 | The evicted block is to be sent to a peer |
| spill_target | output | $clog2(NCORES) | Core that receives the spilled block |

## Verification
A wrong recency rank, singlet flag or spilled flag stays invisible until the affected way becomes a replacement candidate, then shows as a wrong `victim_way` or a wrong `spill_req` on the cycle after that fill. The bench therefore keeps its own per-way model and checks every fill, running long random mixes of hits, directory updates and fills so that corrupted state is forced to the victim position within a handful of replacements. Directed sequences age a spilled block to the bottom of the set with and without an intervening hit, and place an old singlet behind a younger replicated block.

// File: rtl/spill_repl_ctrl.sv
module spill_repl_ctrl #(
  parameter int WAYS    = 8,
  parameter int NCORES  = 4,
  parameter int CORE_ID = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hit_valid,
  input  logic [$clog2(WAYS)-1:0]   hit_way,
  input  logic                      fill_valid,
  input  logic                      fill_singlet,
  input  logic                      fill_from_peer,
  input  logic                      dir_valid,
  input  logic [$clog2(WAYS)-1:0]   dir_way,
  input  logic                      dir_singlet,
  input  logic [7:0]                coop_thresh,
  input  logic [7:0]                spill_thresh,
  output logic                      victim_valid,
  output logic [$clog2(WAYS)-1:0]   victim_way,
  output logic                      spill_req,
  output logic [$clog2(NCORES)-1:0] spill_target
);
  localparam int WW = $clog2(WAYS);
  localparam int CW = $clog2(NCORES);
  localparam logic [WW-1:0] LRU_RANK = WW'(WAYS - 1);

  logic [WW-1:0] rank [WAYS];
  logic [WAYS-1:0] vld, sing, spl;
  logic [15:0] lfsr;

  wire coop  = (coop_thresh == 8'hFF) || (lfsr[7:0] < coop_thresh);
  wire spill = (spill_thresh == 8'hFF) || (lfsr[15:8] < spill_thresh);

  logic          inv_any, rep_any;
  logic [WW-1:0] inv_way, rep_way, rep_rank, lru_way, pick;

  always_comb begin
    inv_any = 1'b0; inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[w]) begin inv_any = 1'b1; inv_way = WW'(w); end
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (rank[w] == LRU_RANK) lru_way = WW'(w);
    rep_any = 1'b0; rep_way = '0; rep_rank = '0;
    for (int w = 0; w < WAYS; w++)
      if (!sing[w] && (!rep_any || rank[w] > rep_rank)) begin
        rep_any = 1'b1; rep_way = WW'(w); rep_rank = rank[w];
      end
    if (inv_any)            pick = inv_way;
    else if (coop && rep_any) pick = rep_way;
    else                    pick = lru_way;
  end

  wire do_spill = !inv_any && coop && sing[pick] && !spl[pick] && spill;

  logic [CW:0] raw, tgt;
  always_comb begin
    raw = {1'b0, lfsr[4 +: CW]};
    if (raw >= (CW+1)'(NCORES)) raw = raw - (CW+1)'(NCORES);
    tgt = raw;
    if (raw == (CW+1)'(CORE_ID))
      tgt = (raw + 1'b1 >= (CW+1)'(NCORES)) ? '0 : raw + 1'b1;
  end

  wire          touch_en  = fill_valid || hit_valid;
  wire [WW-1:0] touch_way = fill_valid ? pick : hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1;
      vld <= '0; sing <= '0; spl <= '0;
      for (int w = 0; w < WAYS; w++) rank[w] <= WW'(w);
      victim_valid <= 1'b0; victim_way <= '0;
      spill_req <= 1'b0; spill_target <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (touch_en)
        for (int w = 0; w < WAYS; w++)
          if (WW'(w) == touch_way) rank[w] <= '0;
          else if (rank[w] < rank[touch_way]) rank[w] <= rank[w] + 1'b1;
      if (dir_valid) sing[dir_way] <= dir_singlet;
      if (fill_valid) begin
        vld[pick]  <= 1'b1;
        sing[pick] <= fill_singlet;
        spl[pick]  <= fill_from_peer;
      end else if (hit_valid) begin
        spl[hit_way] <= 1'b0;
      end
      victim_valid <= fill_valid;
      if (fill_valid) begin
        victim_way   <= pick;
        spill_req    <= do_spill;
        spill_target <= tgt[CW-1:0];
      end else begin
        spill_req <= 1'b0;
      end
    end
  end
endmodule

module spill_repl_chk #(
  parameter int NCORES  = 4,
  parameter int CORE_ID = 0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fill_valid,
  input logic [7:0]                coop_thresh,
  input logic                      victim_valid,
  input logic                      spill_req,
  input logic [$clog2(NCORES)-1:0] spill_target,
  input logic [15:0]               lfsr
);
  p_fill_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> victim_valid);
  p_no_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> !victim_valid);
  p_spill_with_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |-> victim_valid);
  p_coop_off_no_spill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && coop_thresh == 8'h00) |=> !spill_req);
  p_target_peer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |-> (int'(spill_target) != CORE_ID && int'(spill_target) < NCORES));
  p_lfsr_alive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);
endmodule

bind spill_repl_ctrl spill_repl_chk #(.NCORES(NCORES), .CORE_ID(CORE_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .coop_thresh(coop_thresh),
  .victim_valid(victim_valid), .spill_req(spill_req),
  .spill_target(spill_target), .lfsr(lfsr));

// File: tb/sim_spill_repl_ctrl.sv
module sim_spill_repl_ctrl;
  localparam int WAYS = 8, NCORES = 4, CORE_ID = 2, WW = 3, CW = 2;

  logic clk = 0, rst_n = 0;
  logic hit_valid = 0, fill_valid = 0, fill_singlet = 0, fill_from_peer = 0;
  logic dir_valid = 0, dir_singlet = 0;
  logic [WW-1:0] hit_way = 0, dir_way = 0;
  logic [7:0] coop_thresh = 0, spill_thresh = 0;
  logic victim_valid, spill_req;
  logic [WW-1:0] victim_way;
  logic [CW-1:0] spill_target;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int m_rank [WAYS];
  bit m_vld [WAYS], m_sing [WAYS], m_spl [WAYS];

  always #10 clk = ~clk;

  spill_repl_ctrl #(.WAYS(WAYS), .NCORES(NCORES), .CORE_ID(CORE_ID)) u0 (.*);

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void m_touch(int w);
    int r = m_rank[w];
    for (int v = 0; v < WAYS; v++) if (m_rank[v] < r) m_rank[v]++;
    m_rank[w] = 0;
  endfunction

  function automatic int m_victim(bit coop);
    int best = -1;
    for (int w = 0; w < WAYS; w++) if (!m_vld[w]) return w;
    if (coop)
      for (int w = 0; w < WAYS; w++)
        if (!m_sing[w] && (best < 0 || m_rank[w] > m_rank[best])) best = w;
    if (best >= 0) return best;
    for (int w = 0; w < WAYS; w++) if (m_rank[w] == WAYS - 1) return w;
    return 0;
  endfunction

  task automatic do_hit(int w);
    @(negedge clk); hit_valid = 1; hit_way = WW'(w);
    @(negedge clk); hit_valid = 0;
    m_touch(w); m_spl[w] = 0;
    check("R2", "victim_valid idle", int'(victim_valid), 0);
  endtask

  task automatic do_dir(int w, bit s);
    @(negedge clk); dir_valid = 1; dir_way = WW'(w); dir_singlet = s;
    @(negedge clk); dir_valid = 0;
    m_sing[w] = s;
  endtask

  task automatic do_fill(string req, bit coop, bit spl_on, bit s, bit peer);
    int ev; bit es, full;
    full = 1;
    for (int w = 0; w < WAYS; w++) if (!m_vld[w]) full = 0;
    ev = m_victim(coop);
    es = full && coop && m_sing[ev] && !m_spl[ev] && spl_on;
    @(negedge clk);
    fill_valid = 1; fill_singlet = s; fill_from_peer = peer;
    coop_thresh = coop ? 8'hFF : 8'h00; spill_thresh = spl_on ? 8'hFF : 8'h00;
    @(negedge clk); fill_valid = 0;
    check("R2", "victim_valid", int'(victim_valid), 1);
    check(req, "victim_way", int'(victim_way), ev);
    check(req, "spill_req", int'(spill_req), int'(es));
    if (spill_req) begin
      check("R9", "target is peer", int'(int'(spill_target) != CORE_ID), 1);
      check("R9", "target in range", int'(int'(spill_target) < NCORES), 1);
    end
    m_vld[ev] = 1; m_sing[ev] = s; m_spl[ev] = peer; m_touch(ev);
    @(negedge clk);
    check("R2", "single pulse", int'(victim_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < WAYS; w++) begin m_rank[w] = w; m_vld[w] = 0; m_sing[w] = 0; m_spl[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset victim_valid", int'(victim_valid), 0);
    check("R1", "reset spill_req", int'(spill_req), 0);
    // R1: empty ways fill in order, even with spilling enabled
    for (int i = 0; i < WAYS; i++) do_fill("R1", 1, 1, 1, 0);
    // R3: plain LRU with cooperation off
    do_hit(0); do_hit(3);
    do_fill("R3", 0, 1, 1, 0);
    do_fill("R3", 0, 1, 1, 0);
    // R5: all singlets, LRU chosen and spilled
    do_fill("R5", 1, 1, 1, 0);
    // R6: spill threshold 0 suppresses spill
    do_fill("R6", 1, 0, 1, 0);
    // R4: a young replicated block beats an older singlet
    do_dir(5, 0); do_hit(5);
    do_fill("R4", 1, 1, 1, 0);
    // R10: directory update turns a replica back into a singlet
    do_dir(4, 0); do_dir(4, 1);
    do_fill("R10", 1, 1, 1, 0);
    // R7: peer-spilled block aged to LRU is dropped
    do_fill("R7", 1, 1, 1, 1);
    for (int i = 0; i < WAYS - 1; i++) do_fill("R7", 1, 1, 1, 0);
    do_fill("R7", 1, 1, 1, 0);
    // R8: a hit on a spilled block re-enables spilling
    do_fill("R8", 1, 1, 1, 1);
    for (int w = 0; w < WAYS; w++) if (m_rank[w] == 0) do_hit(w);
    for (int i = 0; i < WAYS; i++) do_fill("R8", 1, 1, 1, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) do_hit($urandom_range(0, WAYS - 1));
      else if (op < 5) do_dir($urandom_range(0, WAYS - 1), 1'($urandom_range(0, 1)));
      else do_fill("R6", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule